// File: doc/BRIEF.md
# Nibble-Loaded Cycle IRQ Counter

This block is a free-running 16-bit up-counter that pulls an active-low interrupt request line when it wraps from all ones to zero. The counter advances once for every bus cycle, marked by each falling edge of the M2 bus clock, which is seen through the block's system clock. Software loads the count four bits at a time through four write addresses, one for each nibble, so a full load takes four bus writes and any single nibble can be changed alone.

Two more write addresses complete the register set. One sets the interrupt enable from data bit 0. The other acknowledges a pending interrupt, whatever data is written. The pending flag is sticky: it holds the IRQ line low until it is acknowledged, and it does not depend on later changes to the enable. The block decodes only address bits 14..12 inside the ROM-select window. Other decoding on the same bus is handled elsewhere.

Top module: `nibble_irq_counter`

## Requirements
- R1: A write with A14..A12 = 000, 001, 010 or 011 (CPU addresses $8000, $9000, $A000, $B000) loads D3..D0 into counter bits 3..0, 7..4, 11..8 or 15..12 respectively.
- R2: A nibble write changes only its own four bits. The other twelve keep their value, and the counter does not also advance in that bus cycle.
- R3: A write with A14..A12 = 100 ($C000) sets the interrupt enable to D0 (1 enables, 0 disables).
- R4: A write with A14..A12 = 101 ($D000) clears the pending flag, whatever the data.
- R5: On every M2 falling edge that carries no nibble write (reads, idle cycles and other writes included), the counter increases by one. The change takes effect at the first system-clock edge that sees M2 low after it was high.
- R6: When the counter steps from $FFFF to $0000 while the enable is 1, the pending flag is set. With the enable at 0 the wrap sets nothing. Counting continues from $0000 in both cases.
- R7: The pending flag stays set until it is acknowledged, and a write to the enable does not clear it. irq_n is low exactly while the flag is set.
- R8: If a wrap and an acknowledge write fall in the same bus cycle with the enable at 1, the flag ends that cycle set.
- R9: A write is recognised only when romsel_n is 0 and cpu_rw is 0 at the M2 falling edge. Writes with A14..A12 = 110 or 111, and any cycle that fails this test, have no register effect and only advance the counter.
- R10: With rst_n low at a clock edge, the counter goes to $0000 and the enable and the pending flag go to 0, so irq_n is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than M2 |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 3 | CPU address bits 14..12 |
| cpu_data | input | 4 | CPU data bits 3..0 |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| romsel_n | input | 1 | Active-low select for the $8000-$FFFF window |
| m2 | input | 1 | CPU bus clock; each falling edge ends a bus cycle |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Two pairs of functions can fall on the same M2 edge: a nibble write while the counter would advance, and an acknowledge write while the counter wraps with the enable at 1. The bench creates the first by placing nibble writes among counting cycles. It creates the second on purpose by loading $FFFF with the enable set and then writing the acknowledge address. A bench model then decides the outcome: a nibble write wins over the count, and a wrap wins over the acknowledge. The random phase forces both cases many times by biasing loaded nibbles toward $F. The bench watches irq_n after every bus cycle and compares it with the model.

// File: rtl/nibble_irq_pkg.sv
// Package: shared types for the nibble-loaded IRQ counter.
// Assumes: one bus event per M2 falling edge, decoded in the clk domain.
package nibble_irq_pkg;

    // One decoded bus cycle: the tick, plus the control writes it carries.
    typedef struct packed {
        logic tick;     // M2 falling edge seen this clk cycle
        logic wr_en;    // write to the enable register
        logic wr_ack;   // write to the acknowledge register
    } bus_evt_t;

endpackage

// File: rtl/nibble_irq_decode.sv
// Module: nibble_irq_decode
// Detects the M2 falling edge in the clk domain and decodes the write
// target from address bits 14..12. Assumes clk runs well above M2 and
// that address, data, R/W and ROM select are stable around the M2 fall.
module nibble_irq_decode
    import nibble_irq_pkg::*;
#(
    parameter int unsigned ADDR_W  = 3,
    parameter int unsigned NIBBLES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic               cpu_rw,
    input  logic               romsel_n,
    input  logic               m2,
    output logic [NIBBLES-1:0] wr_nib,
    output bus_evt_t           evt
);

    localparam logic [ADDR_W-1:0] EN_CODE  = ADDR_W'(NIBBLES);
    localparam logic [ADDR_W-1:0] ACK_CODE = ADDR_W'(NIBBLES + 1);

    logic m2_q;
    logic fall;
    logic wr_stb;

    // Remember the previous M2 level so that its falling edge can be seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m2_q <= 1'b0;
        end else begin
            m2_q <= m2;
        end
    end

    // A bus cycle ends where M2 was high and is now low.
    always_comb begin
        fall   = m2_q & ~m2;
        wr_stb = fall & ~romsel_n & ~cpu_rw;
    end

    // One strobe per counter nibble, selected by its own address code.
    for (genvar k = 0; k < NIBBLES; k++) begin : g_nib_sel
        assign wr_nib[k] = wr_stb && (cpu_addr == ADDR_W'(k));
    end

    // Control strobes for the enable and acknowledge registers.
    always_comb begin
        evt.tick   = fall;
        evt.wr_en  = wr_stb && (cpu_addr == EN_CODE);
        evt.wr_ack = wr_stb && (cpu_addr == ACK_CODE);
    end

endmodule

// File: rtl/nibble_irq_count.sv
// Module: nibble_irq_count
// The up-counter, held as separate nibble registers so that each one can
// be loaded on its own. A nibble write takes priority over the increment
// in the same tick. Reports a wrap when it steps from all ones to zero.
module nibble_irq_count #(
    parameter int unsigned NIB_W   = 4,
    parameter int unsigned NIBBLES = 4,
    localparam int unsigned CNT_W  = NIB_W * NIBBLES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic [NIBBLES-1:0] wr_nib,
    input  logic [NIB_W-1:0]   wr_data,
    output logic [CNT_W-1:0]   cnt,
    output logic               wrap
);

    logic [NIB_W-1:0] nib_q [NIBBLES];
    logic [CNT_W-1:0] inc;
    logic             any_wr;
    logic             step;

    // Next count value and whether this tick counts or loads.
    always_comb begin
        any_wr = |wr_nib;
        step   = tick & ~any_wr;
        inc    = cnt + CNT_W'(1);
        wrap   = step & (&cnt);
    end

    // Each nibble is either loaded, stepped with the whole count, or held.
    for (genvar k = 0; k < NIBBLES; k++) begin : g_nib
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                nib_q[k] <= '0;
            end else if (wr_nib[k]) begin
                nib_q[k] <= wr_data;
            end else if (step) begin
                nib_q[k] <= inc[k*NIB_W +: NIB_W];
            end
        end
        assign cnt[k*NIB_W +: NIB_W] = nib_q[k];
    end

endmodule

// File: rtl/nibble_irq_flag.sv
// Module: nibble_irq_flag
// Holds the interrupt enable and the sticky pending flag. A wrap with the
// enable set wins over an acknowledge in the same tick.
module nibble_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic en_bit,
    input  logic wr_ack,
    input  logic wrap,
    output logic en,
    output logic pend
);

    // Enable register: loaded from data bit 0 on its own write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en <= 1'b0;
        end else if (wr_en) begin
            en <= en_bit;
        end
    end

    // Pending flag: set by an enabled wrap, cleared by acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
        end else if (wrap && en) begin
            pend <= 1'b1;
        end else if (wr_ack) begin
            pend <= 1'b0;
        end
    end

endmodule

// File: rtl/nibble_irq_counter.sv
// Module: nibble_irq_counter (top)
// A bus-cycle counter that raises an active-low IRQ when it wraps. The
// count is loaded a nibble at a time, and enable and acknowledge have
// their own addresses. Assumes the clk domain samples M2.
module nibble_irq_counter
    import nibble_irq_pkg::*;
#(
    parameter int unsigned NIB_W   = 4,
    parameter int unsigned NIBBLES = 4,
    parameter int unsigned ADDR_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [NIB_W-1:0]  cpu_data,
    input  logic              cpu_rw,
    input  logic              romsel_n,
    input  logic              m2,
    output logic              irq_n
);

    localparam int unsigned CNT_W = NIB_W * NIBBLES;

    bus_evt_t           evt;
    logic [NIBBLES-1:0] wr_nib;
    logic [CNT_W-1:0]   cnt;
    logic               wrap;
    logic               en;
    logic               pend;

    nibble_irq_decode #(
        .ADDR_W  (ADDR_W),
        .NIBBLES (NIBBLES)
    ) u_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_addr (cpu_addr),
        .cpu_rw   (cpu_rw),
        .romsel_n (romsel_n),
        .m2       (m2),
        .wr_nib   (wr_nib),
        .evt      (evt)
    );

    nibble_irq_count #(
        .NIB_W   (NIB_W),
        .NIBBLES (NIBBLES)
    ) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (evt.tick),
        .wr_nib  (wr_nib),
        .wr_data (cpu_data),
        .cnt     (cnt),
        .wrap    (wrap)
    );

    nibble_irq_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (evt.wr_en),
        .en_bit (cpu_data[0]),
        .wr_ack (evt.wr_ack),
        .wrap   (wrap),
        .en     (en),
        .pend   (pend)
    );

    // The request line follows the pending flag, active low.
    assign irq_n = ~pend;

endmodule

// File: rtl/nibble_irq_counter_chk.sv
// Module: nibble_irq_counter_chk
// Assertion checker bound into nibble_irq_counter. It watches the decoded
// events, the count, and the enable and pending registers.
module nibble_irq_counter_chk #(
    parameter int unsigned NIB_W   = 4,
    parameter int unsigned NIBBLES = 4,
    localparam int unsigned CNT_W  = NIB_W * NIBBLES
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tick,
    input logic               wr_en,
    input logic               wr_ack,
    input logic [NIBBLES-1:0] wr_nib,
    input logic [NIB_W-1:0]   cpu_data,
    input logic [CNT_W-1:0]   cnt,
    input logic               en,
    input logic               pend
);

    for (genvar k = 0; k < NIBBLES; k++) begin : g_nib_chk
        localparam logic [CNT_W-1:0] MASK = CNT_W'({NIB_W{1'b1}}) << (k * NIB_W);

        p_nib_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
            tick && wr_nib[k] |=> cnt[k*NIB_W +: NIB_W] == $past(cpu_data));

        p_nib_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
            tick && wr_nib[k] |=> (cnt & ~MASK) == ($past(cnt) & ~MASK));
    end

    p_one_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_nib, wr_en, wr_ack}));

    p_write_needs_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|{wr_nib, wr_en, wr_ack}) |-> tick);

    p_enable_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> en == $past(cpu_data[0]));

    p_enable_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(en));

    p_ack_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ack && !(en && (&cnt)) |=> !pend);

    p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !(|wr_nib) |=> cnt == CNT_W'($past(cnt) + CNT_W'(1)));

    p_count_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt));

    p_wrap_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !(|wr_nib) && en && (&cnt) |=> pend);

    p_no_set_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !pend && !en |=> !pend);

    p_pend_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pend && !wr_ack |=> pend);

    p_wrap_beats_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ack && en && (&cnt) |=> pend);

    p_reset_state_r10: assert property (@(posedge clk)
        !rst_n |=> (!pend && !en && cnt == '0));

endmodule

bind nibble_irq_counter nibble_irq_counter_chk #(
    .NIB_W   (NIB_W),
    .NIBBLES (NIBBLES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (evt.tick),
    .wr_en    (evt.wr_en),
    .wr_ack   (evt.wr_ack),
    .wr_nib   (wr_nib),
    .cpu_data (cpu_data),
    .cnt      (cnt),
    .en       (en),
    .pend     (pend)
);

// File: tb/nibble_irq_counter_test.sv
// Bench for nibble_irq_counter: directed corner cases, then seeded random
// bus cycles, with irq_n compared to a bench model after every cycle.
module nibble_irq_counter_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cpu_addr = 3'd0;
    logic [3:0] cpu_data = 4'd0;
    logic       cpu_rw = 1'b1;
    logic       romsel_n = 1'b1;
    logic       m2 = 1'b0;
    logic       irq_n;

    int unsigned n_run  = 0;
    int unsigned n_fail = 0;
    bit          done   = 1'b0;

    // Bench model state
    logic [15:0] m_cnt  = 16'h0000;
    logic        m_en   = 1'b0;
    logic        m_pend = 1'b0;

    always #2.5 clk = ~clk;

    nibble_irq_counter uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_addr (cpu_addr),
        .cpu_data (cpu_data),
        .cpu_rw   (cpu_rw),
        .romsel_n (romsel_n),
        .m2       (m2),
        .irq_n    (irq_n)
    );

    // Counter after one bus cycle (R1, R2, R5, R9).
    function automatic logic [15:0] f_cnt(logic [15:0] c, logic wr, logic [2:0] a, logic [3:0] d);
        logic [15:0] r;
        r = c;
        if (wr && a < 3'd4) r[a*4 +: 4] = d;
        else r = c + 16'd1;
        return r;
    endfunction

    // Pending flag after one bus cycle (R4, R6, R7, R8).
    function automatic logic f_pend(logic [15:0] c, logic en, logic p, logic wr, logic [2:0] a);
        logic wrapped;
        wrapped = !(wr && a < 3'd4) && (c == 16'hFFFF);
        if (wrapped && en) return 1'b1;
        if (wr && a == 3'd5) return 1'b0;
        return p;
    endfunction

    // Enable after one bus cycle (R3).
    function automatic logic f_en(logic en, logic wr, logic [2:0] a, logic [3:0] d);
        if (wr && a == 3'd4) return d[0];
        return en;
    endfunction

    task automatic check(input logic act, input logic exp, input string tag);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: irq_n=%0b expected %0b (model cnt=%h en=%0b)",
                     tag, act, exp, m_cnt, m_en);
        end
    endtask

    // One M2 bus cycle; rw=0 with rs=0 is a recognised write.
    task automatic bus(input logic rw, input logic rs, input logic [2:0] a,
                       input logic [3:0] d, input string tag);
        logic wr;
        @(negedge clk);
        cpu_addr = a; cpu_data = d; cpu_rw = rw; romsel_n = rs; m2 = 1'b1;
        @(negedge clk);
        @(negedge clk);
        m2 = 1'b0;
        @(negedge clk);
        cpu_rw = 1'b1; romsel_n = 1'b1;
        wr = !rw && !rs;
        m_pend = f_pend(m_cnt, m_en, m_pend, wr, a);
        m_en   = f_en(m_en, wr, a, d);
        m_cnt  = f_cnt(m_cnt, wr, a, d);
        check(irq_n, ~m_pend, tag);
    endtask

    task automatic wr(input logic [2:0] a, input logic [3:0] d, input string tag);
        bus(1'b0, 1'b0, a, d, tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) bus(1'b1, 1'b1, 3'd0, 4'd0, tag);
    endtask

    task automatic load(input logic [15:0] v, input string tag);
        for (int k = 3; k >= 0; k--) wr(3'(k), v[k*4 +: 4], tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; m2 = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_cnt = 16'h0000; m_en = 1'b0; m_pend = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        for (int i = 0; i < 150000; i++) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        check(irq_n, 1'b1, "R10 reset state");

        // R1/R6: enabled wrap after a full nibble load
        wr(3'd4, 4'h1, "R3 enable on");
        load(16'hFFF0, "R1 nibble load");
        idle(15, "R5 count toward wrap");
        check(irq_n, 1'b1, "R5 no irq before wrap");
        idle(1, "R6 enabled wrap raises irq");
        check(irq_n, 1'b0, "R6 irq low after wrap");

        // R7: disabling keeps the pending flag
        wr(3'd4, 4'h0, "R7 enable off keeps pending");
        idle(3, "R7 pending sticky");
        check(irq_n, 1'b0, "R7 still low");

        // R4: acknowledge with arbitrary data
        wr(3'd5, 4'hA, "R4 ack clears");
        check(irq_n, 1'b1, "R4 irq released");

        // R6: disabled wrap does nothing
        load(16'hFFFE, "R1 load near wrap");
        idle(4, "R6 disabled wrap ignored");
        check(irq_n, 1'b1, "R6 no irq when disabled");

        // R2: single nibble replace keeps the others
        wr(3'd4, 4'h1, "R3 enable on");
        load(16'hFFFF, "R1 load all ones");
        wr(3'd1, 4'h0, "R2 nibble1 only");
        idle(240, "R2 count from FF0F");
        check(irq_n, 1'b1, "R2 no early wrap");
        idle(1, "R2 wrap exactly at FFFF");
        check(irq_n, 1'b0, "R2 wrap timing");
        wr(3'd5, 4'h0, "R4 ack");

        // R9: ignored writes only count
        load(16'hFFF8, "R1 load");
        bus(1'b0, 1'b1, 3'd3, 4'h0, "R9 romsel high write ignored");
        bus(1'b1, 1'b0, 3'd0, 4'h0, "R9 read ignored");
        wr(3'd6, 4'h0, "R9 code 110 ignored");
        wr(3'd7, 4'h0, "R9 code 111 ignored");
        bus(1'b0, 1'b1, 3'd4, 4'h0, "R9 enable write ignored");
        idle(3, "R9 counting continued");
        check(irq_n, 1'b0, "R9 wrap after ignored writes");

        // R8: wrap and ack in the same bus cycle
        load(16'hFFFF, "R1 load all ones");
        wr(3'd5, 4'h3, "R8 wrap beats ack");
        check(irq_n, 1'b0, "R8 still pending");
        wr(3'd5, 4'h0, "R4 ack after coincidence");
        check(irq_n, 1'b1, "R4 cleared");

        // R10: reset mid-operation clears pending and enable
        load(16'hFFFF, "R1 load");
        idle(1, "R6 wrap");
        do_reset();
        check(irq_n, 1'b1, "R10 reset clears pending");
        load(16'hFFFF, "R10 load after reset");
        idle(2, "R10 enable cleared by reset");
        check(irq_n, 1'b1, "R10 no irq with enable cleared");

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            int unsigned op;
            logic [3:0]  d;
            op = $urandom % 16;
            d  = 4'($urandom);
            case (op)
                0, 1, 2, 3, 4: begin
                    if (($urandom % 4) != 0) d = 4'hF;
                    wr(3'($urandom % 4), d, "R1 random nibble");
                end
                5:  wr(3'd4, d, "R3 random enable");
                6:  wr(3'd5, d, "R4 random ack");
                7:  bus(1'b0, 1'b1, 3'($urandom), d, "R9 random romsel high");
                8:  bus(1'b1, 1'b0, 3'($urandom), d, "R9 random read");
                9:  wr(3'd6 + 3'($urandom % 2), d, "R9 random unused code");
                default: idle(1, "R5 random count");
            endcase
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule